// File: doc/BRIEF.md
# LVDS Link Training Pattern Inserter

This block sits in front of the 4:1 serializers of a parallel LVDS transmit link that feeds a display controller. Each half-rate clock cycle it produces one 4-slot nibble per lane: 16 data lanes plus a 17th lane that carries the data-valid strobe. When the receiver raises its init-active status, the block replaces every lane, valid lane included, with a fixed training nibble. The receiver uses that nibble to pick its capture phase. When init-active is low, words from the pixel source pass through unchanged.

The init-active input comes from another clock domain. It passes through a two-flop synchronizer before it is used, and the synchronized value drives a status output. The lane outputs are registered, so a change between training and pass-through always happens on a half-rate clock edge and never splits a nibble. Reset puts the block into training, so the pattern is already on the link before the receiver leaves reset.

The source side is a valid/ready stream. A beat is accepted on a rising edge where both `s_valid` and `s_ready` are high. `s_ready` is low for the whole of training. The source must hold its beat stable until it is accepted, and nothing is dropped. There is no back-pressure toward the serializers: they take a nibble on every cycle.

Top module: `lvds_train_inserter`

## Requirements
- R1: While `rst_n` is low, `training_o` is 1, `s_ready` is 0 and every lane of `ser_d` carries the training nibble.
- R2: Lane l of `ser_d` occupies bits [4l+3:4l], and bit j of a lane is serializer slot D(j+1). Lanes 0..15 are data and lane 16 is the valid lane. The training nibble is D1=0, D2=0, D3=1, D4=0, which is the value 4'b0100 on every one of the 17 lanes.
- R3: A change of `init_active_i` shows on `training_o` after exactly two rising clock edges.
- R4: `s_ready` is low whenever `training_o` is high and high whenever it is low. A beat offered while `s_ready` is low is not taken and does not reach `ser_d`.
- R5: If `training_o` is high before a rising edge, `ser_d` holds the training nibble on all 17 lanes after that edge.
- R6: An accepted beat appears on `ser_d` after the accepting edge. Data lane l takes `s_data[4l+3:4l]` and the valid lane takes `s_vnib`.
- R7: An edge where `training_o` is low and no beat is accepted leaves `ser_d` all zero, with the valid lane low in all four slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate system clock; serializer inputs update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_active_i | input | 1 | Receiver init-active status, asynchronous to `clk` |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Block can take a beat (low during training) |
| s_data | input | 64 | 16 data lanes of 4 slots each |
| s_vnib | input | 4 | Valid-lane nibble for the beat, 4 slots |
| ser_d | output | 68 | 17 lanes of 4 serializer slots |
| training_o | output | 1 | Synchronized init-active status |

## Verification
The assertions check on every cycle that:
- the cycle after a training cycle carries the full 17-lane training word;
- ready is the inverse of the training status;
- accepted beats come out unchanged one edge later;
- idle cycles give an all-zero word;
- a rise of the status follows the input two edges earlier.

The reset state can only be shown by the bench's scenarios, since every clocked property is disabled during reset. The scenarios also cover:
- the exact cycle at which the synchronized status, ready and output change after init-active falls and rises again in the middle of a stream;
- beats held by the source while training is on, which must not leak onto the link.

// File: rtl/lvds_train_pkg.sv
package lvds_train_pkg;
  // serializer slots per lane, bit j = slot D(j+1)
  localparam int unsigned SLOTS = 4;
  // transmitter-side training nibble: D1=0 D2=0 D3=1 D4=0
  localparam logic [SLOTS-1:0] TRAIN_NIB = 4'b0100;
  typedef logic [SLOTS-1:0] nib_t;
endpackage

// File: rtl/lvds_train_sync.sv
module lvds_train_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvds_train_lane.sv
module lvds_train_lane
  import lvds_train_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic train,
  input  logic load,
  input  nib_t nib_i,
  output nib_t nib_q
);
  nib_t nib_d;

  always_comb begin
    if (train)     nib_d = TRAIN_NIB;
    else if (load) nib_d = nib_i;
    else           nib_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nib_q <= TRAIN_NIB;
    else        nib_q <= nib_d;
  end
endmodule

// File: rtl/lvds_train_inserter.sv
module lvds_train_inserter
  import lvds_train_pkg::*;
#(
  parameter int unsigned DATA_LANES  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ALL_LANES  = DATA_LANES + 1,
  localparam int unsigned DW         = DATA_LANES * SLOTS,
  localparam int unsigned OW         = ALL_LANES * SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_active_i,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [SLOTS-1:0] s_vnib,
  output logic [OW-1:0] ser_d,
  output logic          training_o
);
  logic train_sync;
  logic accept;
  logic [OW-1:0] lane_in;

  lvds_train_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (init_active_i),
    .sync_o  (train_sync)
  );

  assign s_ready    = ~train_sync;
  assign training_o = train_sync;
  assign accept     = s_valid & ~train_sync;
  assign lane_in    = {s_vnib, s_data};

  for (genvar l = 0; l < ALL_LANES; l++) begin : g_lane
    lvds_train_lane lane_i (
      .clk   (clk),
      .rst_n (rst_n),
      .train (train_sync),
      .load  (accept),
      .nib_i (lane_in[l*SLOTS +: SLOTS]),
      .nib_q (ser_d[l*SLOTS +: SLOTS])
    );
  end
endmodule

// File: rtl/lvds_train_inserter_chk.sv
module lvds_train_inserter_chk
  import lvds_train_pkg::*;
#(
  parameter int unsigned DATA_LANES = 16,
  localparam int unsigned ALL_LANES = DATA_LANES + 1,
  localparam int unsigned DW        = DATA_LANES * SLOTS,
  localparam int unsigned OW        = ALL_LANES * SLOTS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_active_i,
  input logic          s_valid,
  input logic          s_ready,
  input logic [DW-1:0] s_data,
  input logic [SLOTS-1:0] s_vnib,
  input logic [OW-1:0] ser_d,
  input logic          training_o
);
  localparam logic [OW-1:0] TRAIN_WORD = {ALL_LANES{TRAIN_NIB}};

  AST_TRAIN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    training_o |=> (ser_d == TRAIN_WORD)); // R5

  AST_VALID_LANE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    training_o |=> (ser_d[OW-1 -: SLOTS] == 4'b0100)); // R2

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready == !training_o); // R4

  AST_PASS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (ser_d == {$past(s_vnib), $past(s_data)})); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!training_o && !s_valid) |=> (ser_d == '0)); // R7

  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(training_o) |-> $past(init_active_i, 2)); // R3
endmodule

bind lvds_train_inserter lvds_train_inserter_chk #(.DATA_LANES(DATA_LANES)) chk_i (.*);

// File: tb/lvds_train_inserter_tb_top.sv
module lvds_train_inserter_tb_top;
  localparam int DL = 16;
  localparam int DW = DL * 4;
  localparam int OW = (DL + 1) * 4;
  localparam logic [OW-1:0] PAT = {(DL+1){4'b0100}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_active_i = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DW-1:0] s_data = '0;
  logic [3:0] s_vnib = '0;
  logic [OW-1:0] ser_d;
  logic training_o;

  int tests = 0;
  int fails = 0;
  logic [OW-1:0] exp_q[$];
  string tag_q[$];
  logic m_s1, m_s2;
  logic mon_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvds_train_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .init_active_i(init_active_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_vnib(s_vnib),
    .ser_d(ser_d), .training_o(training_o)
  );

  task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; predict the registered word
  task automatic step(input logic init, input logic vld, input logic [DW-1:0] d,
                      input logic [3:0] vn, input string req);
    @(negedge clk);
    init_active_i = init;
    s_valid = vld;
    s_data = d;
    s_vnib = vn;
    #1;
    chk("R3", OW'(training_o), OW'(m_s2));
    chk("R4", OW'(s_ready), OW'(!m_s2));
    if (m_s2)     exp_q.push_back(PAT);
    else if (vld) exp_q.push_back({vn, d});
    else          exp_q.push_back('0);
    tag_q.push_back(req);
    m_s2 = m_s1;
    m_s1 = init;
  endtask

  // monitor: compare the word each edge produces
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && exp_q.size() > 0) begin
        automatic logic [OW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, ser_d, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    s_valid = 1'b1;
    s_data = {DL{4'hA}};
    #1;
    chk("R1", OW'(training_o), OW'(1));
    chk("R1", OW'(s_ready), OW'(0));
    chk("R1", ser_d, PAT);
    chk("R2", OW'(ser_d[OW-1 -: 4]), OW'(4'b0100));
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_s1 = 1'b1;
    m_s2 = 1'b1;
    mon_on = 1'b1;
    // R5: hold training; offered beats must be ignored (R4)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, {DL{4'hF}}, 4'hF, "R5");
    // drop init-active; R3 latency, then pass-through
    step(1'b0, 1'b1, {DL{4'h3}}, 4'hF, "R4");
    step(1'b0, 1'b1, {DL{4'h3}}, 4'hF, "R4");
    step(1'b0, 1'b1, {DL{4'h3}}, 4'hF, "R6");
    step(1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 4'h5, "R6");
    step(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, "R7");
    step(1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 4'hA, "R6");
    for (int i = 0; i < 8; i++)
      step(1'b0, 1'b1, {DL{4'(i)}} ^ 64'h5A5A_A5A5_0F0F_F0F0, 4'(i), "R6");
    step(1'b0, 1'b0, '0, 4'h0, "R7");
    step(1'b0, 1'b0, '0, 4'h9, "R7");
    // raise init-active mid-stream
    step(1'b1, 1'b1, {DL{4'hC}}, 4'hF, "R6");
    step(1'b1, 1'b1, {DL{4'hC}}, 4'hF, "R6");
    step(1'b1, 1'b1, {DL{4'hC}}, 4'hF, "R5");
    step(1'b1, 1'b0, '0, 4'h0, "R2");
    step(1'b0, 1'b1, {DL{4'h1}}, 4'h1, "R5");
    step(1'b0, 1'b1, {DL{4'h1}}, 4'h1, "R4");
    step(1'b0, 1'b1, {DL{4'h1}}, 4'h1, "R6");
    step(1'b0, 1'b0, '0, 4'h0, "R7");
    @(negedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule